// File: doc/BRIEF.md
# Top-of-Memory System Register Decoder

This block sits next to a 32-bit CPU and turns each bus access into a region select or a register access. Low addresses go to on-chip RAM. A large window below the top of memory goes to the graphics unit. A small cluster of addresses holds the button inputs and a simulation stop trigger. The top 64 bytes hold eight 8-byte slots: two read-only counters, a reserved slot, the interrupt table base, the two stack pointers, the program counter and the flags word. The CPU also uses the block to form the address of an interrupt vector: the table base plus four times the interrupt number.

Each access is qualified by `bus_req` and is a write when `bus_we` is high. Register read data comes out one cycle after the request. Data for RAM and graphics reads is muxed outside this block, so `rd_data` carries zero for those reads. An access that matches no region reads zero and raises a one-cycle error strobe.

The stop trigger is a two-state machine:
- **ST_RUN** is the reset state. A write to the stop address takes the transition **RUN_TO_HALT**.
- **ST_HALT** holds `sim_stop` high. Its only transition is **HALT_HOLD**, back to itself, until reset.

Top module: `sysreg_decoder`

## Requirements
- R1: After reset, every register slot (including the program counter) and both counters read zero, and `rd_data`, `decode_err` and `sim_stop` are low.
- R2: The clock counter at 0xFFFFFFC8 advances by one on every clock after reset. A read returns the number of edges seen since reset, sampled at the request edge.
- R3: The instruction counter at 0xFFFFFFC0 advances by one on each clock where `instr_ret` is high, and holds otherwise.
- R4: The window 0xFFFFFFC0–0xFFFFFFFF is decoded by address bits 5:3. Slot 3 is the interrupt table base, 4 the data stack pointer, 5 the return stack pointer, 6 the program counter and 7 the flags. All five are read/write.
- R5: Writes to the counter slots (0, 1) and the reserved slot (2) have no effect. The reserved slot reads zero.
- R6: A read of 0xE0060000 returns `buttons` in bits 11:0 and zero in bits 31:12. The bit order, from bit 11 down to bit 0, is a, b, x, y, up, down, left, right, l, r, start, select. Writes to this address are ignored.
- R7: A write of any value to 0xE0060040 raises `sim_stop` from the next cycle until reset. Reads of that address read zero and do not stop.
- R8: `vec_addr` equals the interrupt table base plus 4 × `irq_num`, combinationally. For example, interrupt 8 gives base + 0x20.
- R9: When `bus_req` is high, `ram_sel` is high in the same cycle for addresses below RAM_BYTES (default 0x80000), and `gpu_sel` is high for 0xE8000000 up to 0xFFFFFFBF. At most one of the two is ever high.
- R10: A request to any other address returns zero and pulses `decode_err` for exactly the one cycle after it.
- R11: `rd_data` is registered with one cycle of latency. It is zero after a write, after an idle cycle, and after a RAM or graphics access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Register read data, one cycle after the request |
| instr_ret | input | 1 | One instruction retired this cycle |
| buttons | input | 12 | Live button levels |
| irq_num | input | IRQ_W | Interrupt number for the vector address |
| vec_addr | output | 32 | Vector-fetch address |
| ram_sel | output | 1 | Current access targets RAM |
| gpu_sel | output | 1 | Current access targets the graphics window |
| decode_err | output | 1 | Previous access hit no region |
| sim_stop | output | 1 | Stop requested (sticky) |

## Verification
The decoder is driven with addresses placed on each side of every region edge: the last RAM word and the first byte past RAM, the first graphics byte and the last one below the register window, and the words next to the button and stop addresses. These separate an off-by-one in each range compare from a wrong region priority. Register slots are written with distinct patterns and then read back in a different order, which exposes swapped slot decoding. Counter reads are spread across idle and retiring cycles, so a counter that stalls, double-steps or accepts a write is told apart from a correct one. Button patterns with alternating and all-ones bits show any bit reordering or leak into the upper bits.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam logic [31:0] SYS_BASE  = 32'hFFFF_FFC0;
    localparam logic [31:0] GPU_BASE  = 32'hE800_0000;
    localparam logic [31:0] BTN_ADDR  = 32'hE006_0000;
    localparam logic [31:0] STOP_ADDR = 32'hE006_0040;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_RAM,
        RG_GPU,
        RG_SYS,
        RG_BTN,
        RG_STOP
    } region_e;

    typedef enum logic [2:0] {
        SL_ICNT  = 3'd0,
        SL_CLK   = 3'd1,
        SL_RSVD  = 3'd2,
        SL_ITB   = 3'd3,
        SL_DSP   = 3'd4,
        SL_RSP   = 3'd5,
        SL_PC    = 3'd6,
        SL_FLAGS = 3'd7
    } slot_e;

    typedef enum logic {
        ST_RUN,
        ST_HALT
    } stop_state_e;

endpackage

// File: rtl/sysreg_addr_decode.sv
module sysreg_addr_decode
    import sysreg_pkg::*;
#(
    parameter logic [31:0] RAM_BYTES = 32'h0008_0000
) (
    input  logic [31:0] addr,
    output region_e     region
);
    always_comb begin
        if (addr >= SYS_BASE) begin
            region = RG_SYS;
        end else if (addr >= GPU_BASE) begin
            region = RG_GPU;
        end else if (addr == BTN_ADDR) begin
            region = RG_BTN;
        end else if (addr == STOP_ADDR) begin
            region = RG_STOP;
        end else if (addr < RAM_BYTES) begin
            region = RG_RAM;
        end else begin
            region = RG_NONE;
        end
    end
endmodule

// File: rtl/sysreg_counters.sv
module sysreg_counters #(
    parameter int DATA_W  = 32,
    parameter int NUM_CNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CNT-1:0] inc,
    output logic [DATA_W-1:0] cnt_q [NUM_CNT]
);
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (inc[g]) begin
                cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sysreg_rw_file.sv
module sysreg_rw_file #(
    parameter int DATA_W     = 32,
    parameter int FIRST_SLOT = 3,
    parameter int NUM_RW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        slot,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rw_q [NUM_RW]
);
    for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
        localparam logic [2:0] MY_SLOT = 3'(FIRST_SLOT + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rw_q[g] <= '0;
            end else if (wr_en && slot == MY_SLOT) begin
                rw_q[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/sysreg_stop_fsm.sv
module sysreg_stop_fsm
    import sysreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_wr,
    output logic sim_stop
);
    stop_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (stop_wr) state_d = ST_HALT;  // RUN_TO_HALT
            ST_HALT: state_d = ST_HALT;               // HALT_HOLD
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  sim_stop = 1'b0;
            ST_HALT: sim_stop = 1'b1;
            default: sim_stop = 1'b0;
        endcase
    end
endmodule

// File: rtl/sysreg_decoder.sv
module sysreg_decoder
    import sysreg_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          BTN_W     = 12,
    parameter int          IRQ_W     = 8,
    parameter logic [31:0] RAM_BYTES = 32'h0008_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [31:0]       bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic              instr_ret,
    input  logic [BTN_W-1:0]  buttons,
    input  logic [IRQ_W-1:0]  irq_num,
    output logic [DATA_W-1:0] vec_addr,
    output logic              ram_sel,
    output logic              gpu_sel,
    output logic              decode_err,
    output logic              sim_stop
);
    localparam int NUM_CNT    = 2;
    localparam int FIRST_SLOT = 3;
    localparam int NUM_RW     = 8 - FIRST_SLOT;
    localparam int VEC_PAD    = DATA_W - IRQ_W - 2;

    region_e           region;
    slot_e             slot;
    logic [DATA_W-1:0] cnt_q [NUM_CNT];
    logic [DATA_W-1:0] rw_q  [NUM_RW];
    logic [DATA_W-1:0] clk_cnt;
    logic [DATA_W-1:0] ins_cnt;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rd_q;
    logic              err_q;
    logic              rw_wr;
    logic              stop_wr;

    assign slot = slot_e'(bus_addr[5:3]);

    sysreg_addr_decode #(.RAM_BYTES(RAM_BYTES)) u_dec (
        .addr   (bus_addr),
        .region (region)
    );

    sysreg_counters #(.DATA_W(DATA_W), .NUM_CNT(NUM_CNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   ({1'b1, instr_ret}),
        .cnt_q (cnt_q)
    );
    assign ins_cnt = cnt_q[0];
    assign clk_cnt = cnt_q[1];

    assign rw_wr = bus_req && bus_we && (region == RG_SYS);

    sysreg_rw_file #(.DATA_W(DATA_W), .FIRST_SLOT(FIRST_SLOT), .NUM_RW(NUM_RW)) u_rw (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (rw_wr),
        .slot  (bus_addr[5:3]),
        .wdata (bus_wdata),
        .rw_q  (rw_q)
    );

    assign stop_wr = bus_req && bus_we && (region == RG_STOP);

    sysreg_stop_fsm u_stop (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_wr  (stop_wr),
        .sim_stop (sim_stop)
    );

    always_comb begin
        rd_next = '0;
        unique case (region)
            RG_SYS: begin
                unique case (slot)
                    SL_ICNT: rd_next = ins_cnt;
                    SL_CLK:  rd_next = clk_cnt;
                    SL_RSVD: rd_next = '0;
                    default: rd_next = rw_q[3'(slot) - 3'(FIRST_SLOT)];
                endcase
            end
            RG_BTN:  rd_next = {{(DATA_W-BTN_W){1'b0}}, buttons};
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else begin
            rd_q  <= (bus_req && !bus_we) ? rd_next : '0;
            err_q <= bus_req && (region == RG_NONE);
        end
    end

    assign rd_data    = rd_q;
    assign decode_err = err_q;
    assign ram_sel    = bus_req && (region == RG_RAM);
    assign gpu_sel    = bus_req && (region == RG_GPU);
    assign vec_addr   = rw_q[0] + {{VEC_PAD{1'b0}}, irq_num, 2'b00};
endmodule

// File: rtl/sysreg_decoder_chk.sv
module sysreg_decoder_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              instr_ret,
    input logic              ram_sel,
    input logic              gpu_sel,
    input logic              decode_err,
    input logic              sim_stop,
    input logic [DATA_W-1:0] clk_cnt,
    input logic [DATA_W-1:0] ins_cnt
);
    // R2
    clk_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> clk_cnt == $past(clk_cnt) + 1'b1);

    // R3
    icnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(instr_ret)) |-> $stable(ins_cnt));

    // R7
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sim_stop |=> sim_stop);

    // R9
    sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, gpu_sel}));

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_err && $past(rst_n)) |-> ($past(bus_req) && !$past(ram_sel) && !$past(gpu_sel)));
endmodule

bind sysreg_decoder sysreg_decoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .instr_ret  (instr_ret),
    .ram_sel    (ram_sel),
    .gpu_sel    (gpu_sel),
    .decode_err (decode_err),
    .sim_stop   (sim_stop),
    .clk_cnt    (clk_cnt),
    .ins_cnt    (ins_cnt)
);

// File: tb/sysreg_decoder_tb.sv
module sysreg_decoder_tb;
    localparam int IRQ_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic        instr_ret = 1'b0;
    logic [11:0] buttons = '0;
    logic [IRQ_W-1:0] irq_num = '0;
    logic [31:0] vec_addr;
    logic        ram_sel, gpu_sel, decode_err, sim_stop;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sysreg_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .instr_ret(instr_ret), .buttons(buttons), .irq_num(irq_num),
        .vec_addr(vec_addr), .ram_sel(ram_sel), .gpu_sel(gpu_sel),
        .decode_err(decode_err), .sim_stop(sim_stop)
    );

    // Behavioural reference model
    longint unsigned m_clk, m_ins;
    logic [31:0] m_slot [8];
    logic [31:0] e_rd;
    logic        e_err, m_stop;

    // 0 none, 1 ram, 2 gpu, 3 sys, 4 btn, 5 stop
    function automatic int classify(input logic [31:0] a);
        if (a >= 32'hFFFF_FFC0) return 3;
        if (a >= 32'hE800_0000) return 2;
        if (a == 32'hE006_0000) return 4;
        if (a == 32'hE006_0040) return 5;
        if (a < 32'h0008_0000)  return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clk = 0; m_ins = 0; e_rd = '0; e_err = 1'b0; m_stop = 1'b0;
            for (int i = 0; i < 8; i++) m_slot[i] = '0;
        end else begin
            int r;
            int s;
            r = classify(bus_addr);
            s = int'(bus_addr[5:3]);
            e_rd  = '0;
            e_err = bus_req && (r == 0);
            if (bus_req && !bus_we) begin
                if (r == 3) begin
                    if (s == 0)      e_rd = 32'(m_ins);
                    else if (s == 1) e_rd = 32'(m_clk);
                    else if (s == 2) e_rd = '0;
                    else             e_rd = m_slot[s];
                end else if (r == 4) begin
                    e_rd = {20'b0, buttons};
                end
            end
            if (bus_req && bus_we) begin
                if (r == 3 && s >= 3) m_slot[s] = bus_wdata;
                if (r == 5) m_stop = 1'b1;
            end
            m_clk++;
            if (instr_ret) m_ins++;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge: apply stimulus, check combinational outputs,
    // advance one clock, check registered outputs at the next falling edge.
    task automatic step(input string tag, input logic req, input logic we,
                        input logic [31:0] a, input logic [31:0] d, input logic ins);
        int r;
        bus_req = req; bus_we = we; bus_addr = a; bus_wdata = d; instr_ret = ins;
        #1;
        r = classify(a);
        chk(tag, "ram_sel", 32'(ram_sel), 32'(req && r == 1));
        chk(tag, "gpu_sel", 32'(gpu_sel), 32'(req && r == 2));
        chk(tag, "vec_addr", vec_addr, m_slot[3] + {22'b0, irq_num, 2'b00});
        @(posedge clk);
        @(negedge clk);
        chk(tag, "rd_data", rd_data, e_rd);
        chk(tag, "decode_err", 32'(decode_err), 32'(e_err));
        chk(tag, "sim_stop", 32'(sim_stop), 32'(m_stop));
    endtask

    task automatic rd(input string tag, input logic [31:0] a);
        step(tag, 1'b1, 1'b0, a, 32'h0, 1'b0);
    endtask

    task automatic wr(input string tag, input logic [31:0] a, input logic [31:0] d);
        step(tag, 1'b1, 1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input string tag, input logic ins);
        step(tag, 1'b0, 1'b0, 32'h0, 32'h0, ins);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "rd_data", rd_data, 32'h0);
        chk("R1", "decode_err", 32'(decode_err), 32'h0);
        chk("R1", "sim_stop", 32'(sim_stop), 32'h0);
        chk("R1", "vec_addr", vec_addr, 32'h0);
        rst_n = 1'b1;
        for (int s = 0; s < 8; s++) rd("R1", 32'hFFFF_FFC0 + 32'(s * 8));

        // R2: clock counter across idle gaps
        rd("R2", 32'hFFFF_FFC8);
        idle("R2", 1'b0);
        idle("R2", 1'b0);
        rd("R2", 32'hFFFF_FFC8);
        rd("R2", 32'hFFFF_FFCC);

        // R3: instruction counter with mixed retire pattern
        idle("R3", 1'b1);
        idle("R3", 1'b0);
        idle("R3", 1'b1);
        idle("R3", 1'b1);
        rd("R3", 32'hFFFF_FFC0);
        step("R3", 1'b1, 1'b0, 32'hFFFF_FFC0, 32'h0, 1'b1);
        rd("R3", 32'hFFFF_FFC0);

        // R4: writable slots, read back in another order
        wr("R4", 32'hFFFF_FFD8, 32'h0000_1F00);
        wr("R4", 32'hFFFF_FFE0, 32'h0000_1D00);
        wr("R4", 32'hFFFF_FFE8, 32'h0000_1E00);
        wr("R4", 32'hFFFF_FFF0, 32'hCAFE_0004);
        wr("R4", 32'hFFFF_FFF8, 32'h8000_0001);
        rd("R4", 32'hFFFF_FFF8);
        rd("R4", 32'hFFFF_FFE0);
        rd("R4", 32'hFFFF_FFF0);
        rd("R4", 32'hFFFF_FFD8);
        rd("R4", 32'hFFFF_FFE8);

        // R8: vector address
        irq_num = 8'd8;
        idle("R8", 1'b0);
        irq_num = 8'd255;
        idle("R8", 1'b0);
        irq_num = 8'd0;
        idle("R8", 1'b0);

        // R5: read-only counters and reserved slot
        wr("R5", 32'hFFFF_FFC0, 32'hFFFF_FFFF);
        wr("R5", 32'hFFFF_FFC8, 32'h1234_5678);
        wr("R5", 32'hFFFF_FFD0, 32'hDEAD_BEEF);
        rd("R5", 32'hFFFF_FFD0);
        rd("R5", 32'hFFFF_FFC0);
        rd("R5", 32'hFFFF_FFC8);

        // R6: button register
        buttons = 12'hA5C;
        rd("R6", 32'hE006_0000);
        buttons = 12'hFFF;
        wr("R6", 32'hE006_0000, 32'h0000_0000);
        rd("R6", 32'hE006_0000);
        buttons = 12'h801;
        rd("R6", 32'hE006_0000);

        // R9: region edges
        rd("R9", 32'h0000_0000);
        rd("R9", 32'h0007_FFFC);
        wr("R9", 32'h0000_0100, 32'h1);
        rd("R9", 32'hE800_0000);
        rd("R9", 32'hFFFF_FFBC);
        rd("R9", 32'hFFFF_FFC0);

        // R10: unmapped addresses
        rd("R10", 32'h0008_0000);
        idle("R10", 1'b0);
        rd("R10", 32'hE006_0004);
        wr("R10", 32'hE7FF_FFFC, 32'h5);
        rd("R10", 32'hE006_003C);

        // R11: zero after write, idle and memory access
        wr("R11", 32'hFFFF_FFF8, 32'h0000_00AA);
        idle("R11", 1'b0);
        rd("R11", 32'hFFFF_FFF8);
        rd("R11", 32'h0000_0040);

        // R7: stop trigger
        rd("R7", 32'hE006_0040);
        idle("R7", 1'b0);
        wr("R7", 32'hE006_0040, 32'h0000_0001);
        idle("R7", 1'b0);
        rd("R7", 32'hFFFF_FFD8);
        idle("R7", 1'b0);

        finish_run();
    end
endmodule